// File: doc/BRIEF.md
# Hierarchical Software Reset Controller

The controller turns software writes into reset pulses for fourteen reset domains: twelve single peripherals, the watchdog and the CPU. Software writes a 1 to a bit in one of two reset registers. Every domain covered by that bit receives a reset pulse of fixed length. Each domain answers on its own done line once it has come out of reset. The bit stays readable as 1 until every domain it covers has answered, so software starts a reset and then polls until the bit returns to 0.

Besides the single-domain bits, three scope bits reach several domains at once, and each scope contains the one before it:

- **Peripheral scope:** every peripheral except the pin controller (GPIO) and the watchdog.
- **Soft scope:** the peripheral scope plus GPIO.
- **System scope:** everything, including the watchdog and the CPU.

A system reset blocks new requests while it runs. When it finishes, the controller's pending state is empty. The register port has no back-pressure: a write is taken in the cycle `wr_en` is high, and reads are combinational.

Top module: `swrst_ctrl`

## Requirements
- R1: Domain indices are DMA 0, watchdog 1, GPIO 2, timers 3 to 5, UARTs 6 and 7, SPIs 8 and 9, I2C0 10, RTC 11, I2C1 12 and CPU 13. In register 0, these bits each start one domain:
  - bit 0: DMA
  - bit 1: watchdog
  - bit 2: GPIO
  - bits 5, 6, 7: timers 0, 1, 2
  - bits 11, 12: UARTs 0, 1
  - bits 13, 14: SPIs 0, 1
  - bit 16: I2C0
  - bit 17: RTC

  In register 1, bit 0 starts I2C1.
- R2: Bit 30 of register 0 resets domains 0 and 3 to 12 (mask 0x1FF9). It leaves the watchdog, GPIO and CPU alone.
- R3: Bit 29 of register 0 resets the peripheral set plus GPIO (mask 0x1FFD), but not the watchdog or the CPU.
- R4: Bit 31 of register 0 resets all fourteen domains (mask 0x3FFF), including the watchdog and the CPU.
- R5: A reset output rises in the cycle after the write that starts it. It stays high for exactly HOLD cycles (default 4), and a done input that is high during those cycles does not shorten it.
- R6: A written bit reads 1 from the cycle after the write. After the hold ends, a domain completes on the first clock edge at which its done input is high. The bit reads 0 one cycle after the last domain it covers has completed, and it stays 1 for as long as any covered done input remains low.
- R7: Writing 0 has no effect. Writing to a bit position that has no reset function, in either register, also has no effect. In both cases no output rises and the readback stays 0.
- R8: All bits set in one write start their resets in the same cycle. A register-0 write of 0x00037800 pulses domains 6 to 11 together, and a write of 0x19 starts only DMA.
- R9: While the system bit is pending, writes to either register are ignored. When the system reset completes, every bit in both registers reads 0 and no domain is busy.
- R10: While reset is applied and after it is released, all reset outputs are low and both registers read 0.
- R11: `rd_sel` = 0 returns register 0 and `rd_sel` = 1 returns register 1. Positions with no reset function read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the controller |
| wr_en | input | 1 | Write strobe, taken at the rising edge |
| wr_sel | input | 1 | Write target: 0 = register 0, 1 = register 1 |
| wr_data | input | 32 | Write data; a 1 starts the matching reset |
| rd_sel | input | 1 | Read select: 0 = register 0, 1 = register 1 |
| rd_data | output | 32 | Combinational readback of the pending bits |
| dom_done | input | 14 | Per-domain completion, level sensitive |
| dom_rst | output | 14 | Per-domain reset outputs, active high |

## Verification
The assertions take two things for granted:
- HOLD is at least 1.
- A done input is a level that a domain holds until the controller has seen it. If a done is held high from the start, the domain completes right after its hold.

The stimulus keeps within this by driving done from the bench as a steady mask that changes only at falling clock edges. Some tests keep done low to stretch the waiting phase and then release it in stages, so that a partly completed scope can be seen. Writes are issued one per access, also at falling edges. Some of them deliberately land while a system reset is pending.

// File: rtl/swrst_pkg.sv
`timescale 1ns/1ps
package swrst_pkg;
  localparam int NUM_DOM = 14;
  localparam int NUM_REQ = 16;
  localparam int REQ_SYS = 14;

  localparam logic [NUM_DOM-1:0] MASK_PERIPH = 14'h1FF9;
  localparam logic [NUM_DOM-1:0] MASK_SOFT   = 14'h1FFD;
  localparam logic [NUM_DOM-1:0] MASK_ALL    = 14'h3FFF;

  // Register bit position of each request (software-visible layout).
  function automatic int req_pos(input int i);
    case (i)
      0: return 0;   1: return 1;   2: return 2;
      3: return 5;   4: return 6;   5: return 7;
      6: return 11;  7: return 12;  8: return 13;
      9: return 14;  10: return 16; 11: return 17;
      12: return 29; 13: return 30; 14: return 31;
      default: return 0;
    endcase
  endfunction

  // Which register (0 or 1) holds the request.
  function automatic logic req_reg(input int i);
    return (i == NUM_REQ - 1);
  endfunction

  // Domains reached by each request.
  function automatic logic [NUM_DOM-1:0] req_mask(input int i);
    case (i)
      12: return MASK_SOFT;
      13: return MASK_PERIPH;
      14: return MASK_ALL;
      15: return NUM_DOM'(1) << 12;
      default: return NUM_DOM'(1) << i;
    endcase
  endfunction
endpackage

// File: rtl/swrst_domain.sv
`timescale 1ns/1ps
module swrst_domain #(
  parameter int HOLD = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic done_i,
  output logic rst_o,
  output logic busy_o
);
  localparam int CW = $clog2(HOLD + 1);

  typedef enum logic [1:0] {D_IDLE, D_HOLD, D_WAIT} dstate_t;
  dstate_t       state_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= D_IDLE;
      cnt_q   <= '0;
    end else if (start_i) begin
      state_q <= D_HOLD;
      cnt_q   <= CW'(HOLD - 1);
    end else begin
      case (state_q)
        D_HOLD: begin
          if (cnt_q == '0) state_q <= D_WAIT;
          else             cnt_q   <= cnt_q - 1'b1;
        end
        D_WAIT: if (done_i) state_q <= D_IDLE;
        default: ;
      endcase
    end
  end

  assign rst_o  = (state_q == D_HOLD);
  assign busy_o = (state_q != D_IDLE);

  // Pulse-length observer for the hold check.
  logic [CW:0] run_q;
  always_ff @(posedge clk) begin
    if (!rst_n)                run_q <= '0;
    else if (!rst_o)           run_q <= '0;
    else if (run_q != '1)      run_q <= run_q + 1'b1;
  end

  assert_hold_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_o) |-> (run_q >= (CW+1)'(HOLD)));

  assert_rise_on_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_o) |-> $past(start_i));
endmodule

// File: rtl/swrst_bits.sv
`timescale 1ns/1ps
module swrst_bits
  import swrst_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               wr_sel,
  input  logic [31:0]        wr_data,
  input  logic               rd_sel,
  input  logic [NUM_DOM-1:0] dom_busy,
  output logic [NUM_DOM-1:0] start_o,
  output logic               sys_busy_o,
  output logic [31:0]        rd_data
);
  logic [NUM_REQ-1:0] pend_q, pend_d, hit, cov_busy;
  logic               sys_done;
  logic               unused_wr;

  assign unused_wr = ^wr_data;

  for (genvar i = 0; i < NUM_REQ; i++) begin : g_req
    assign hit[i] = wr_en & ~pend_q[REQ_SYS] & (wr_sel == req_reg(i))
                  & wr_data[req_pos(i)];
    assign cov_busy[i] = |(req_mask(i) & dom_busy);

    assert_set_drives_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend_q[i]) |-> cov_busy[i]);
  end

  always_comb begin
    start_o = '0;
    for (int i = 0; i < NUM_REQ; i++)
      if (hit[i]) start_o = start_o | req_mask(i);
  end

  assign sys_done = pend_q[REQ_SYS] & ~cov_busy[REQ_SYS];

  always_comb begin
    if (sys_done) pend_d = '0;
    else          pend_d = hit | (pend_q & cov_busy);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_REQ; i++)
      if (req_reg(i) == rd_sel) rd_data[req_pos(i)] = pend_q[i];
  end

  assign sys_busy_o = pend_q[REQ_SYS];
endmodule

// File: rtl/swrst_ctrl.sv
`timescale 1ns/1ps
module swrst_ctrl
  import swrst_pkg::*;
#(
  parameter int HOLD = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               wr_sel,
  input  logic [31:0]        wr_data,
  input  logic               rd_sel,
  output logic [31:0]        rd_data,
  input  logic [NUM_DOM-1:0] dom_done,
  output logic [NUM_DOM-1:0] dom_rst
);
  logic [NUM_DOM-1:0] start, busy;
  logic               sys_busy;

  swrst_bits u_bits (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_sel     (wr_sel),
    .wr_data    (wr_data),
    .rd_sel     (rd_sel),
    .dom_busy   (busy),
    .start_o    (start),
    .sys_busy_o (sys_busy),
    .rd_data    (rd_data)
  );

  for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
    swrst_domain #(.HOLD(HOLD)) u_dom (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (start[d]),
      .done_i  (dom_done[d]),
      .rst_o   (dom_rst[d]),
      .busy_o  (busy[d])
    );
  end

  assert_sys_block_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_busy && $past(sys_busy)) |-> ((dom_rst & ~$past(dom_rst)) == '0));

  assert_sys_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sys_busy) |-> (busy == '0));

  assert_hold_scope_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dom_rst[13]) |-> (dom_rst == MASK_ALL));
endmodule

// File: tb/swrst_ctrl_test.sv
`timescale 1ns/1ps
module swrst_ctrl_test;
  localparam int HOLD = 4;
  localparam int NV = 11;

  localparam logic        TV_SEL  [NV] = '{0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0};
  localparam logic [31:0] TV_DATA [NV] = '{32'h1, 32'h2, 32'h4, 32'hE0,
    32'h0003_7800, 32'h4000_0000, 32'h2000_0000, 32'h8000_0000, 32'h1,
    32'h8000_0001, 32'h19};
  localparam logic [13:0] TV_MASK [NV] = '{14'h0001, 14'h0002, 14'h0004,
    14'h0038, 14'h0FC0, 14'h1FF9, 14'h1FFD, 14'h3FFF, 14'h1000, 14'h3FFF,
    14'h0001};
  localparam logic [31:0] TV_RB   [NV] = '{32'h1, 32'h2, 32'h4, 32'hE0,
    32'h0003_7800, 32'h4000_0000, 32'h2000_0000, 32'h8000_0000, 32'h1,
    32'h8000_0001, 32'h1};

  logic        clk = 0;
  logic        rst_n = 0;
  logic        wr_en = 0, wr_sel = 0, rd_sel = 0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [13:0] dom_done = '0;
  logic [13:0] dom_rst;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  swrst_ctrl #(.HOLD(HOLD)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
    .dom_done(dom_done), .dom_rst(dom_rst)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(input logic s, output logic [31:0] v);
    rd_sel = s;
    #0.2;
    v = rd_data;
  endtask

  // Ends at the falling edge after the write edge.
  task automatic wr(input logic s, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 0; wr_data = '0;
  endtask

  initial begin
    #1_000_000;
    total++; bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    // R10 during and after reset
    step(3);
    chk("R10 rst during reset", 32'(dom_rst), 32'h0);
    rst_n = 1;
    step(2);
    chk("R10 rst after reset", 32'(dom_rst), 32'h0);
    rd(0, v); chk("R10 reg0 after reset", v, 32'h0);
    rd(1, v); chk("R10 reg1 after reset", v, 32'h0);

    // Table: R1 R2 R3 R4 R5 R6 R8 R11 with done held high
    dom_done = '1;
    for (int k = 0; k < NV; k++) begin
      wr(TV_SEL[k], TV_DATA[k]);
      chk($sformatf("R1/R2/R3/R4/R8 mask v%0d", k), 32'(dom_rst), 32'(TV_MASK[k]));
      rd(TV_SEL[k], v); chk($sformatf("R6/R11 set v%0d", k), v, TV_RB[k]);
      step(HOLD - 1);
      chk($sformatf("R5 still high v%0d", k), 32'(dom_rst), 32'(TV_MASK[k]));
      step(1);
      chk($sformatf("R5 low after hold v%0d", k), 32'(dom_rst), 32'h0);
      step(1);
      rd(TV_SEL[k], v); chk($sformatf("R6 held v%0d", k), v, TV_RB[k]);
      step(1);
      rd(TV_SEL[k], v); chk($sformatf("R6 cleared v%0d", k), v, 32'h0);
      step(2);
    end

    // R7 writes of zero and of unused positions
    wr(0, 32'h0);
    chk("R7 zero write rst", 32'(dom_rst), 32'h0);
    wr(0, 32'h0000_0118);
    chk("R7 unused reg0 rst", 32'(dom_rst), 32'h0);
    rd(0, v); chk("R7 unused reg0 rb", v, 32'h0);
    wr(1, 32'hFFFF_FFFE);
    chk("R7 unused reg1 rst", 32'(dom_rst), 32'h0);
    rd(1, v); chk("R7 unused reg1 rb", v, 32'h0);
    rd(0, v); chk("R11 reg0 after reg1 write", v, 32'h0);

    // R6 completion waits on done from every covered domain
    dom_done = '0;
    wr(0, 32'h4000_0000);
    chk("R2 periph mask", 32'(dom_rst), 32'h1FF9);
    step(HOLD);
    chk("R5 low without done", 32'(dom_rst), 32'h0);
    step(10);
    rd(0, v); chk("R6 waits for done", v, 32'h4000_0000);
    dom_done = 14'h0001;
    step(3);
    rd(0, v); chk("R6 partial done", v, 32'h4000_0000);
    dom_done = '1;
    step(2);
    rd(0, v); chk("R6 all done", v, 32'h0);

    // R9 system blocks writes and leaves everything clear
    dom_done = '0;
    wr(0, 32'h8000_0000);
    chk("R4 system mask", 32'(dom_rst), 32'h3FFF);
    step(HOLD + 2);
    wr(0, 32'h1);
    chk("R9 write ignored rst", 32'(dom_rst), 32'h0);
    rd(0, v); chk("R9 write ignored rb", v, 32'h8000_0000);
    wr(1, 32'h1);
    rd(1, v); chk("R9 reg1 ignored", v, 32'h0);
    dom_done = '1;
    step(2);
    rd(0, v); chk("R9 reg0 clear", v, 32'h0);
    rd(1, v); chk("R9 reg1 clear", v, 32'h0);
    step(3);
    chk("R9 no late pulse", 32'(dom_rst), 32'h0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule